// File: doc/BRIEF.md
# Debug Access Port Protection Gate

This block sits between a debug host and two access ports. One is a bus port, which reaches the flash, the configuration words and the RAM. The other is a control port, which reports status and runs a whole-device erase. A protection word lives in a small nonvolatile configuration area.

After every reset the gate runs a short boot window, then samples that word and latches the protection decision. While protection is latched, the bus port refuses every transaction. The control port answers at all times. An erase-all command on the control port wipes flash, the configuration area and RAM, which leaves the protection word in its erased, unprotected form. The lock only lifts at the next reset, once the word is sampled again.

Both ports use a one-cycle request/response handshake. A request is sampled on a clock edge, and the response is valid for one cycle after that edge.

Top module: `dbg_access_gate`

## Requirements
- R1: From reset until BOOT_CYCLES clock edges after reset is released, every bus-port request gets an error response. During that time the protection output reads active, and status bit 2 (boot done) reads 0.
- R2: At the end of boot, the gate samples the configuration word at byte address 0x10001208. If its low byte is 0xFF, protection is off. Any other value turns protection on, so 0xFFFFFF00 and 0xFFFFFFFE both lock, while 0x000000FF does not.
- R3: While protection is on, every bus-port read or write gets a response one cycle after the request, with error set and read data equal to zero.
- R4: While protection is off and no erase is running, bus-port accesses respond one cycle after the request with no error. Reads return the stored word and writes store the word. The address map is: flash words from byte address 0, four configuration words from 0x10001200, and RAM words from 0x20000000. An access outside these ranges gets an error.
- R5: The control port answers every request one cycle later, with or without protection. Its status word holds protection active in bit 0, erase busy in bit 1 and boot done in bit 2. Command 0 reads status; command 1 starts erase-all.
- R6: Erase-all keeps the busy flag set for exactly FLASH_WORDS+CFG_WORDS+RAM_WORDS cycles. An erase command that arrives while busy is set is ignored.
- R7: After erase-all, flash and configuration words read 0xFFFFFFFF and RAM words read 0.
- R8: Neither a bus write to the protection word nor an erase changes the latched protection before the next reset.
- R9: While an erase is running, the bus port refuses every request with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bap_req | input | 1 | Bus-port request strobe |
| bap_we | input | 1 | Bus-port write (1) or read (0) |
| bap_addr | input | 32 | Bus-port byte address |
| bap_wdata | input | 32 | Bus-port write data |
| bap_rsp | output | 1 | Bus-port response valid |
| bap_err | output | 1 | Bus-port request refused or unmapped |
| bap_rdata | output | 32 | Bus-port read data, zero on error |
| cap_req | input | 1 | Control-port request strobe |
| cap_cmd | input | 2 | Control-port command |
| cap_rsp | output | 1 | Control-port response valid |
| cap_rdata | output | 32 | Control-port status word |
| prot_active | output | 1 | Latched protection state |

## Verification
The protection word is set to the three values shown in R2, and after each one a reset separates the lock that applies on the next boot from the word just written. The bus port is tried in four states: during boot, locked, unlocked, and during an erase. A read that succeeds in one state and the same read that is refused in another confirm that the gating, not the address, causes the error. The erase is timed by polling status every cycle, and a second erase command is injected during the wipe, so a restarted walk would show up as a longer busy window.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;

    localparam logic [31:0] FLASH_BASE = 32'h0000_0000;
    localparam logic [31:0] CFG_BASE   = 32'h1000_1200;
    localparam logic [31:0] RAM_BASE   = 32'h2000_0000;
    localparam int unsigned PROT_IDX   = 2;   // word 0x10001208

    typedef enum logic [1:0] {
        REG_FLASH = 2'd0,
        REG_CFG   = 2'd1,
        REG_RAM   = 2'd2,
        REG_NONE  = 2'd3
    } region_e;

    typedef struct packed {
        region_e     region;
        logic [15:0] idx;
    } mem_acc_t;

    typedef enum logic [1:0] {
        CMD_STATUS = 2'd0,
        CMD_ERASE  = 2'd1
    } cap_cmd_e;

    typedef struct packed {
        logic [28:0] rsvd;
        logic        booted;
        logic        busy;
        logic        locked;
    } cap_status_t;

    // Low byte 0xFF means unprotected; anything else fails safe to locked.
    function automatic logic prot_from_word(logic [31:0] w);
        return w[7:0] != 8'hFF;
    endfunction

    function automatic mem_acc_t decode_addr(logic [31:0] a, int unsigned fw,
                                             int unsigned cw, int unsigned rw);
        mem_acc_t    d;
        logic [31:0] off;
        d.region = REG_NONE;
        d.idx    = '0;
        off      = '0;
        if (a - FLASH_BASE < fw * 4) begin
            d.region = REG_FLASH;
            off      = a - FLASH_BASE;
        end else if (a >= CFG_BASE && a - CFG_BASE < cw * 4) begin
            d.region = REG_CFG;
            off      = a - CFG_BASE;
        end else if (a >= RAM_BASE && a - RAM_BASE < rw * 4) begin
            d.region = REG_RAM;
            off      = a - RAM_BASE;
        end
        d.idx = off[17:2];
        return d;
    endfunction

endpackage

// File: rtl/dgate_boot.sv
module dgate_boot
    import dbg_gate_pkg::*;
#(
    parameter int unsigned BOOT_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] prot_word,
    output logic        booted,
    output logic        locked
);
    localparam int unsigned CW = $clog2(BOOT_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            booted <= 1'b0;
            locked <= 1'b1;
        end else if (!booted) begin
            if (cnt_q == CW'(BOOT_CYCLES - 1)) begin
                booted <= 1'b1;
                locked <= prot_from_word(prot_word);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R1: fail-safe lock until boot completes
    a_r1_locked_in_boot: assert property (@(posedge clk) disable iff (rst)
        !booted |-> locked);

    // R8: latched decision holds until the next reset
    a_r8_lock_held: assert property (@(posedge clk) disable iff (rst)
        (booted && $past(booted)) |-> $stable(locked));

endmodule

// File: rtl/dgate_store.sv
module dgate_store
    import dbg_gate_pkg::*;
#(
    parameter int unsigned FLASH_WORDS = 16,
    parameter int unsigned CFG_WORDS   = 4,
    parameter int unsigned RAM_WORDS   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  mem_acc_t    acc,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        erase_start,
    output logic        busy,
    output logic [31:0] prot_word
);
    localparam int unsigned TOTAL = FLASH_WORDS + CFG_WORDS + RAM_WORDS;
    localparam int unsigned EW    = $clog2(TOTAL);
    localparam int unsigned FAW   = $clog2(FLASH_WORDS);
    localparam int unsigned CAW   = $clog2(CFG_WORDS);
    localparam int unsigned RAW   = $clog2(RAM_WORDS);

    // Nonvolatile arrays: not cleared by reset.
    logic [31:0] flash_q [FLASH_WORDS];
    logic [31:0] cfg_q   [CFG_WORDS];
    logic [31:0] ram_q   [RAM_WORDS];

    logic [EW-1:0] ecnt_q;
    mem_acc_t      er_acc, w_acc;
    logic [31:0]   w_val;
    logic          w_en;

    always_comb begin
        logic [31:0] e;
        e = 32'(ecnt_q);
        er_acc.region = REG_RAM;
        er_acc.idx    = 16'(e - FLASH_WORDS - CFG_WORDS);
        if (e < FLASH_WORDS) begin
            er_acc.region = REG_FLASH;
            er_acc.idx    = e[15:0];
        end else if (e < FLASH_WORDS + CFG_WORDS) begin
            er_acc.region = REG_CFG;
            er_acc.idx    = 16'(e - FLASH_WORDS);
        end
    end

    always_comb begin
        if (busy) begin
            w_acc = er_acc;
            w_val = (er_acc.region == REG_RAM) ? 32'h0 : 32'hFFFF_FFFF;
            w_en  = 1'b1;
        end else begin
            w_acc = acc;
            w_val = wdata;
            w_en  = wr_en;
        end
    end

    always_ff @(posedge clk) begin
        if (w_en) begin
            case (w_acc.region)
                REG_FLASH: flash_q[w_acc.idx[FAW-1:0]] <= w_val;
                REG_CFG:   cfg_q[w_acc.idx[CAW-1:0]]   <= w_val;
                REG_RAM:   ram_q[w_acc.idx[RAW-1:0]]   <= w_val;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            ecnt_q <= '0;
        end else if (!busy) begin
            if (erase_start) begin
                busy   <= 1'b1;
                ecnt_q <= '0;
            end
        end else if (ecnt_q == EW'(TOTAL - 1)) begin
            busy <= 1'b0;
        end else begin
            ecnt_q <= ecnt_q + 1'b1;
        end
    end

    always_comb begin
        case (acc.region)
            REG_FLASH: rdata = flash_q[acc.idx[FAW-1:0]];
            REG_CFG:   rdata = cfg_q[acc.idx[CAW-1:0]];
            REG_RAM:   rdata = ram_q[acc.idx[RAW-1:0]];
            default:   rdata = 32'h0;
        endcase
    end

    assign prot_word = cfg_q[PROT_IDX];

    // R6: the walk finishes on the last word
    a_r6_erase_ends: assert property (@(posedge clk) disable iff (rst)
        (busy && ecnt_q == EW'(TOTAL - 1)) |=> !busy);

    // R6: a start while busy does not rewind the walk
    a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && ecnt_q != EW'(TOTAL - 1)) |=> (ecnt_q == $past(ecnt_q) + 1'b1));

endmodule

// File: rtl/dgate_bap.sv
module dgate_bap
    import dbg_gate_pkg::*;
#(
    parameter int unsigned FLASH_WORDS = 16,
    parameter int unsigned CFG_WORDS   = 4,
    parameter int unsigned RAM_WORDS   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic        we,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    input  logic        allow,
    input  logic        erasing,
    input  logic [31:0] st_rdata,
    output mem_acc_t    st_acc,
    output logic        st_wen,
    output logic [31:0] st_wdata,
    output logic        rsp,
    output logic        err,
    output logic [31:0] rdata
);
    logic hit, grant;

    assign st_acc   = decode_addr(addr, FLASH_WORDS, CFG_WORDS, RAM_WORDS);
    assign hit      = st_acc.region != REG_NONE;
    assign grant    = req && allow && hit;
    assign st_wen   = grant && we;
    assign st_wdata = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp   <= 1'b0;
            err   <= 1'b0;
            rdata <= '0;
        end else begin
            rsp   <= req;
            err   <= req && !grant;
            rdata <= (grant && !we) ? st_rdata : 32'h0;
        end
    end

    // R3: refused requests answer next cycle with error and no data
    a_r3_refuse_no_data: assert property (@(posedge clk) disable iff (rst)
        (req && !allow) |=> (rsp && err && rdata == 32'h0));

    // R9: an active erase blocks the bus port
    a_r9_erase_blocks: assert property (@(posedge clk) disable iff (rst)
        (req && erasing) |=> err);

endmodule

// File: rtl/dgate_cap.sv
module dgate_cap
    import dbg_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic [1:0]  cmd,
    input  logic        locked,
    input  logic        busy,
    input  logic        booted,
    output logic        erase_start,
    output logic        rsp,
    output logic [31:0] rdata
);
    cap_status_t st;

    assign erase_start = req && (cap_cmd_e'(cmd) == CMD_ERASE) && !busy;

    always_comb begin
        st        = '0;
        st.locked = locked;
        st.busy   = busy;
        st.booted = booted;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp   <= 1'b0;
            rdata <= '0;
        end else begin
            rsp   <= req;
            rdata <= req ? st : 32'h0;
        end
    end

    // R5: control port always answers
    a_r5_cap_answers: assert property (@(posedge clk) disable iff (rst)
        req |=> rsp);

endmodule

// File: rtl/dbg_access_gate.sv
module dbg_access_gate
    import dbg_gate_pkg::*;
#(
    parameter int unsigned FLASH_WORDS = 16,
    parameter int unsigned CFG_WORDS   = 4,
    parameter int unsigned RAM_WORDS   = 8,
    parameter int unsigned BOOT_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bap_req,
    input  logic        bap_we,
    input  logic [31:0] bap_addr,
    input  logic [31:0] bap_wdata,
    output logic        bap_rsp,
    output logic        bap_err,
    output logic [31:0] bap_rdata,
    input  logic        cap_req,
    input  logic [1:0]  cap_cmd,
    output logic        cap_rsp,
    output logic [31:0] cap_rdata,
    output logic        prot_active
);
    logic        booted, locked, busy, erase_start, st_wen, allow;
    logic [31:0] st_rdata, st_wdata, prot_word;
    mem_acc_t    st_acc;

    assign allow       = booted && !locked && !busy;
    assign prot_active = locked;

    dgate_boot #(.BOOT_CYCLES(BOOT_CYCLES)) boot_i (
        .clk(clk), .rst(rst), .prot_word(prot_word),
        .booted(booted), .locked(locked)
    );

    dgate_store #(.FLASH_WORDS(FLASH_WORDS), .CFG_WORDS(CFG_WORDS),
                  .RAM_WORDS(RAM_WORDS)) store_i (
        .clk(clk), .rst(rst), .acc(st_acc), .wr_en(st_wen),
        .wdata(st_wdata), .rdata(st_rdata), .erase_start(erase_start),
        .busy(busy), .prot_word(prot_word)
    );

    dgate_bap #(.FLASH_WORDS(FLASH_WORDS), .CFG_WORDS(CFG_WORDS),
                .RAM_WORDS(RAM_WORDS)) bap_i (
        .clk(clk), .rst(rst), .req(bap_req), .we(bap_we),
        .addr(bap_addr), .wdata(bap_wdata), .allow(allow), .erasing(busy),
        .st_rdata(st_rdata), .st_acc(st_acc), .st_wen(st_wen),
        .st_wdata(st_wdata), .rsp(bap_rsp), .err(bap_err), .rdata(bap_rdata)
    );

    dgate_cap cap_i (
        .clk(clk), .rst(rst), .req(cap_req), .cmd(cap_cmd),
        .locked(locked), .busy(busy), .booted(booted),
        .erase_start(erase_start), .rsp(cap_rsp), .rdata(cap_rdata)
    );

endmodule

// File: tb/dbg_access_gate_tb_top.sv
`timescale 1ns/1ps
module dbg_access_gate_tb_top;

    localparam int FW = 16, CW = 4, RW = 8, BOOT = 8;
    localparam int TOTAL = FW + CW + RW;
    localparam logic [31:0] PROT_A = 32'h1000_1208;
    localparam logic [31:0] RAM_A  = 32'h2000_0000;

    logic        clk = 1'b0, rst = 1'b1;
    logic        bap_req = 0, bap_we = 0;
    logic [31:0] bap_addr = 0, bap_wdata = 0;
    logic        bap_rsp, bap_err;
    logic [31:0] bap_rdata;
    logic        cap_req = 0;
    logic [1:0]  cap_cmd = 0;
    logic        cap_rsp;
    logic [31:0] cap_rdata;
    logic        prot_active;

    int checks = 0, errors = 0;
    logic        r_rsp, r_err;
    logic [31:0] r_data;

    always #2.5 clk = ~clk;

    dbg_access_gate dut_i (
        .clk(clk), .rst(rst), .bap_req(bap_req), .bap_we(bap_we),
        .bap_addr(bap_addr), .bap_wdata(bap_wdata), .bap_rsp(bap_rsp),
        .bap_err(bap_err), .bap_rdata(bap_rdata), .cap_req(cap_req),
        .cap_cmd(cap_cmd), .cap_rsp(cap_rsp), .cap_rdata(cap_rdata),
        .prot_active(prot_active)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_boot();
        repeat (BOOT + 2) @(negedge clk);
    endtask

    task automatic bus(input logic we, input logic [31:0] a, input logic [31:0] d);
        bap_req = 1'b1; bap_we = we; bap_addr = a; bap_wdata = d;
        @(negedge clk);
        bap_req = 1'b0;
        r_rsp = bap_rsp; r_err = bap_err; r_data = bap_rdata;
    endtask

    task automatic cap(input logic [1:0] c);
        cap_req = 1'b1; cap_cmd = c;
        @(negedge clk);
        cap_req = 1'b0;
        r_rsp = cap_rsp; r_data = cap_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * TOTAL; i++) begin
            cap(2'd0);
            if (!r_data[1]) break;
        end
    endtask

    task automatic t_boot_refusal();
        do_reset();
        bus(1'b0, 32'h0, 32'h0);
        chk(r_rsp && r_err && r_data == 0, "R1 bus refused in boot", {30'h0, r_rsp, r_err}, 32'h3);
        cap(2'd0);
        chk(r_rsp && r_data[2:0] == 3'b001, "R1/R5 status in boot", r_data, 32'h1);
        chk(prot_active == 1'b1, "R1 prot active in boot", {31'h0, prot_active}, 32'h1);
    endtask

    task automatic t_erase_timing();
        int cnt;
        @(negedge clk);
        cap_req = 1'b1; cap_cmd = 2'd1;
        @(negedge clk);
        cap_cmd = 2'd0;
        chk(cap_rsp, "R5 erase acknowledged", {31'h0, cap_rsp}, 32'h1);
        cnt = 0;
        for (int i = 0; i < 4 * TOTAL; i++) begin
            cap_cmd = (cnt == 3) ? 2'd1 : 2'd0;  // late erase must be ignored
            @(negedge clk);
            if (cap_rdata[1]) cnt++;
            else break;
        end
        cap_req = 1'b0;
        chk(cnt == TOTAL, "R6 busy window length", cnt, TOTAL);
    endtask

    task automatic t_erased_content();
        do_reset(); wait_boot();
        chk(prot_active == 1'b0, "R2 erased word unlocks", {31'h0, prot_active}, 32'h0);
        bus(1'b0, 32'h0000_0004, 0);
        chk(!r_err && r_data == 32'hFFFF_FFFF, "R7 flash erased", r_data, 32'hFFFF_FFFF);
        bus(1'b0, PROT_A, 0);
        chk(!r_err && r_data == 32'hFFFF_FFFF, "R7 config erased", r_data, 32'hFFFF_FFFF);
        bus(1'b0, RAM_A + 32'd28, 0);
        chk(!r_err && r_data == 32'h0, "R7 ram cleared", r_data, 32'h0);
    endtask

    task automatic t_unlocked_access();
        bus(1'b1, 32'h0000_0008, 32'hDEAD_BEEF);
        chk(r_rsp && !r_err, "R4 flash write ok", {31'h0, r_err}, 32'h0);
        bus(1'b1, RAM_A + 32'd4, 32'h1234_5678);
        bus(1'b0, 32'h0000_0008, 0);
        chk(r_rsp && !r_err && r_data == 32'hDEAD_BEEF, "R4 flash readback", r_data, 32'hDEAD_BEEF);
        bus(1'b0, RAM_A + 32'd4, 0);
        chk(r_data == 32'h1234_5678, "R4 ram readback", r_data, 32'h1234_5678);
        bus(1'b0, 32'h3000_0000, 0);
        chk(r_rsp && r_err && r_data == 0, "R4 unmapped error", {31'h0, r_err}, 32'h1);
        bus(1'b0, 32'h0000_0000 + FW * 4, 0);
        chk(r_err, "R4 past flash end error", {31'h0, r_err}, 32'h1);
    endtask

    task automatic t_lock_cycle();
        bus(1'b1, PROT_A, 32'hFFFF_FF00);
        chk(prot_active == 1'b0, "R8 write not immediate", {31'h0, prot_active}, 32'h0);
        bus(1'b0, 32'h0000_0008, 0);
        chk(!r_err && r_data == 32'hDEAD_BEEF, "R8 still accessible", r_data, 32'hDEAD_BEEF);
        do_reset(); wait_boot();
        chk(prot_active == 1'b1, "R2 0xFFFFFF00 locks", {31'h0, prot_active}, 32'h1);
        bus(1'b0, 32'h0000_0008, 0);
        chk(r_rsp && r_err && r_data == 0, "R3 locked read refused", r_data, 32'h0);
        bus(1'b1, RAM_A, 32'h5555_AAAA);
        chk(r_rsp && r_err && r_data == 0, "R3 locked write refused", {31'h0, r_err}, 32'h1);
        cap(2'd0);
        chk(r_rsp && r_data[2:0] == 3'b101, "R5 status while locked", r_data, 32'h5);
        cap(2'd1);
        wait_idle();
        chk(prot_active == 1'b1, "R8 erase keeps lock", {31'h0, prot_active}, 32'h1);
        bus(1'b0, RAM_A, 0);
        chk(r_err, "R8 still refused after erase", {31'h0, r_err}, 32'h1);
        do_reset(); wait_boot();
        chk(prot_active == 1'b0, "R2 reset after erase unlocks", {31'h0, prot_active}, 32'h0);
    endtask

    task automatic t_busy_refusal();
        cap(2'd1);
        bus(1'b0, RAM_A, 0);
        chk(r_rsp && r_err && r_data == 0, "R9 bus refused while erasing", {31'h0, r_err}, 32'h1);
        wait_idle();
        bus(1'b0, RAM_A, 0);
        chk(!r_err, "R9 bus served after erase", {31'h0, r_err}, 32'h0);
    endtask

    task automatic t_partial_words();
        bus(1'b1, PROT_A, 32'hFFFF_FFFE);
        do_reset(); wait_boot();
        chk(prot_active == 1'b1, "R2 0xFFFFFFFE locks", {31'h0, prot_active}, 32'h1);
        cap(2'd1); wait_idle();
        do_reset(); wait_boot();
        bus(1'b1, PROT_A, 32'h0000_00FF);
        do_reset(); wait_boot();
        chk(prot_active == 1'b0, "R2 0x000000FF unlocks", {31'h0, prot_active}, 32'h0);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_boot_refusal();
        t_erase_timing();
        t_erased_content();
        t_unlocked_access();
        t_lock_cycle();
        t_busy_refusal();
        t_partial_words();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule